// File: doc/BRIEF.md
# Transmit/Receive Buffer Pair with DMA Request Thresholds

This block sits between a processor or DMA side and a serial shift engine. It holds two independent first-in first-out buffers of 16-bit words, eight entries deep by default. One carries outgoing words from the host to the engine, and the other carries received words from the engine back to the host. The serial engine and the bus protocol are not part of the block. Plain one-cycle push and pop strobes stand in for both sides.

Each direction has a DMA request output, gated by its own enable input and compared against a programmable threshold. The outgoing buffer requests service when it has enough free slots. The incoming buffer requests service when it holds enough filled slots. Each buffer can be emptied by a one-cycle clear strobe and reports its occupancy on a port. Three sticky error flags record these events:
- an engine pop from an empty outgoing buffer, which returns zeros;
- a push dropped because the incoming buffer was full;
- a push dropped because the outgoing buffer was full.

Top module: `ff_fifo_pair`

## Requirements
- R1: Each buffer returns words in the order they were pushed. Its occupancy count, 0 to DEPTH, is on `tx_count` / `rx_count`. Popped data appears on the data output after the clock edge that takes the pop.
- R2: A threshold code n means n+1 entries. Both thresholds load from `cfg_tx_lvl` / `cfg_rx_lvl` when `cfg_we` is high, and reset to code 7, which means 8 entries.
- R3: `tx_dma_req` is high exactly when the outgoing free-slot count is at least the outgoing threshold and `tx_dma_en` was high at the last clock edge.
- R4: `rx_dma_req` is high exactly when the incoming filled-slot count is at least the incoming threshold and `rx_dma_en` was high at the last clock edge.
- R5: A one-cycle `tx_clr` / `rx_clr` strobe empties its buffer. The clear wins over a push or pop to that buffer in the same cycle: the push is discarded and the pop returns zeros.
- R6: A push to a full incoming buffer is discarded and sets `err_flags[1]` (receive overrun). The count stays DEPTH and the stored words are unchanged.
- R7: A push to a full outgoing buffer is discarded and sets `err_flags[2]` (transmit overrun). The count stays DEPTH and the stored words are unchanged.
- R8: An engine pop from an empty outgoing buffer sets `err_flags[0]` (underrun) and drives zeros on `eng_tx_data`.
- R9: Each error flag stays set until a 1 on the matching bit of `flag_clr` (bit 0 underrun, bit 1 receive overrun, bit 2 transmit overrun). A set event in the same cycle wins over the clear.
- R10: After a synchronous reset the following hold:
  - both counts are 0;
  - all error flags are 0;
  - both data outputs are 0;
  - `rx_dma_req` is 0;
  - `tx_dma_req` follows `tx_dma_en`, because 8 free slots meet the default threshold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Load both threshold codes |
| cfg_tx_lvl | input | LW (3) | Outgoing threshold code, n means n+1 free slots |
| cfg_rx_lvl | input | LW (3) | Incoming threshold code, n means n+1 filled slots |
| tx_dma_en | input | 1 | Outgoing DMA request enable |
| rx_dma_en | input | 1 | Incoming DMA request enable |
| tx_clr | input | 1 | Empty the outgoing buffer |
| rx_clr | input | 1 | Empty the incoming buffer |
| flag_clr | input | 3 | Write-one-to-clear strobes for `err_flags` |
| host_tx_push | input | 1 | Host pushes a word into the outgoing buffer |
| host_tx_data | input | DATA_W | Word pushed by the host |
| host_rx_pop | input | 1 | Host pops a word from the incoming buffer |
| host_rx_data | output | DATA_W | Last word popped by the host |
| eng_tx_pop | input | 1 | Engine requests the next outgoing word |
| eng_tx_data | output | DATA_W | Word delivered to the engine, zeros on underrun |
| eng_rx_push | input | 1 | Engine pushes a received word |
| eng_rx_data | input | DATA_W | Word received by the engine |
| tx_count | output | CW (4) | Outgoing occupancy |
| rx_count | output | CW (4) | Incoming occupancy |
| tx_dma_req | output | 1 | Outgoing DMA request |
| rx_dma_req | output | 1 | Incoming DMA request |
| err_flags | output | 3 | Sticky flags: [0] underrun, [1] receive overrun, [2] transmit overrun |

## Verification
A buffer clear and a push or pop to the same buffer can arrive in the same cycle. A flag set event and its write-one-to-clear strobe can also coincide. The bench provokes the first case by raising `tx_clr` together with a host push and an engine pop on a partly filled buffer, and `rx_clr` together with an engine push. It judges the result by a zero count, zero popped data and no underrun flag. The second case pairs an underrun pop with `flag_clr[0]` and expects the flag to remain set.

// File: rtl/ff_pkg.sv
package ff_pkg;
  localparam int FLAG_N      = 3;
  localparam int FLAG_UNDER  = 0;
  localparam int FLAG_RX_OVR = 1;
  localparam int FLAG_TX_OVR = 2;

  typedef enum logic {CNT_FILLED = 1'b0, CNT_FREE = 1'b1} lvl_mode_e;
endpackage

// File: rtl/ff_sfifo.sv
module ff_sfifo #(
  parameter int W     = 16,
  parameter int DEPTH = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          push,
  input  logic [W-1:0]  push_data,
  input  logic          pop,
  output logic [W-1:0]  pop_data,
  output logic [CW-1:0] count,
  output logic [CW-1:0] count_nxt,
  output logic          push_drop,
  output logic          pop_empty
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          full, empty, do_push, do_pop;

  assign full      = (count == CW'(DEPTH));
  assign empty     = (count == '0);
  assign do_push   = push & ~clr & ~full;
  assign do_pop    = pop & ~clr & ~empty;
  assign push_drop = push & ~clr & full;
  assign pop_empty = pop & empty;

  always_comb begin
    if (clr) count_nxt = '0;
    else begin
      case ({do_push, do_pop})
        2'b10:   count_nxt = count + CW'(1);
        2'b01:   count_nxt = count - CW'(1);
        default: count_nxt = count;
      endcase
    end
  end

  // storage without reset so it maps onto block RAM
  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp       <= '0;
      rp       <= '0;
      count    <= '0;
      pop_data <= '0;
    end else begin
      count <= count_nxt;
      if (clr) begin
        wp <= '0;
        rp <= '0;
      end else begin
        if (do_push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + AW'(1);
        if (do_pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + AW'(1);
      end
      if (pop) pop_data <= do_pop ? mem[rp] : '0;
    end
  end
endmodule

// File: rtl/ff_dma_req.sv
module ff_dma_req
  import ff_pkg::*;
#(
  parameter int        DEPTH = 8,
  parameter lvl_mode_e MODE  = CNT_FILLED,
  localparam int LW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] count_nxt,
  input  logic [LW-1:0] lvl,
  input  logic          en,
  output logic          req
);
  logic [CW-1:0] metric;
  logic [CW-1:0] thr;

  assign thr = CW'(lvl) + CW'(1);

  generate
    if (MODE == CNT_FREE) begin : g_free
      assign metric = CW'(DEPTH) - count_nxt;
    end else begin : g_filled
      assign metric = count_nxt;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) req <= 1'b0;
    else     req <= en && (metric >= thr);
  end
endmodule

// File: rtl/ff_sticky.sv
module ff_sticky #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] q
);
  generate
    for (genvar i = 0; i < N; i++) begin : g_bit
      always_ff @(posedge clk) begin
        if (rst)         q[i] <= 1'b0;
        else if (set[i]) q[i] <= 1'b1;
        else if (clr[i]) q[i] <= 1'b0;
      end
    end
  endgenerate
endmodule

// File: rtl/ff_fifo_pair.sv
module ff_fifo_pair
  import ff_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 8,
  localparam int LW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [LW-1:0]     cfg_tx_lvl,
  input  logic [LW-1:0]     cfg_rx_lvl,
  input  logic              tx_dma_en,
  input  logic              rx_dma_en,
  input  logic              tx_clr,
  input  logic              rx_clr,
  input  logic [FLAG_N-1:0] flag_clr,
  input  logic              host_tx_push,
  input  logic [DATA_W-1:0] host_tx_data,
  input  logic              host_rx_pop,
  output logic [DATA_W-1:0] host_rx_data,
  input  logic              eng_tx_pop,
  output logic [DATA_W-1:0] eng_tx_data,
  input  logic              eng_rx_push,
  input  logic [DATA_W-1:0] eng_rx_data,
  output logic [CW-1:0]     tx_count,
  output logic [CW-1:0]     rx_count,
  output logic              tx_dma_req,
  output logic              rx_dma_req,
  output logic [FLAG_N-1:0] err_flags
);
  logic [LW-1:0]     tx_lvl_q, rx_lvl_q;
  logic [CW-1:0]     tx_cnt_nxt, rx_cnt_nxt;
  logic              tx_drop, tx_under, rx_drop, rx_under_unused;
  logic [FLAG_N-1:0] flag_set;

  // threshold codes, default is the deepest setting
  always_ff @(posedge clk) begin
    if (rst) begin
      tx_lvl_q <= LW'(DEPTH - 1);
      rx_lvl_q <= LW'(DEPTH - 1);
    end else if (cfg_we) begin
      tx_lvl_q <= cfg_tx_lvl;
      rx_lvl_q <= cfg_rx_lvl;
    end
  end

  ff_sfifo #(.W(DATA_W), .DEPTH(DEPTH)) u_tx_fifo (
    .clk(clk), .rst(rst), .clr(tx_clr),
    .push(host_tx_push), .push_data(host_tx_data),
    .pop(eng_tx_pop), .pop_data(eng_tx_data),
    .count(tx_count), .count_nxt(tx_cnt_nxt),
    .push_drop(tx_drop), .pop_empty(tx_under)
  );

  ff_sfifo #(.W(DATA_W), .DEPTH(DEPTH)) u_rx_fifo (
    .clk(clk), .rst(rst), .clr(rx_clr),
    .push(eng_rx_push), .push_data(eng_rx_data),
    .pop(host_rx_pop), .pop_data(host_rx_data),
    .count(rx_count), .count_nxt(rx_cnt_nxt),
    .push_drop(rx_drop), .pop_empty(rx_under_unused)
  );

  ff_dma_req #(.DEPTH(DEPTH), .MODE(CNT_FREE)) u_tx_req (
    .clk(clk), .rst(rst), .count_nxt(tx_cnt_nxt),
    .lvl(tx_lvl_q), .en(tx_dma_en), .req(tx_dma_req)
  );

  ff_dma_req #(.DEPTH(DEPTH), .MODE(CNT_FILLED)) u_rx_req (
    .clk(clk), .rst(rst), .count_nxt(rx_cnt_nxt),
    .lvl(rx_lvl_q), .en(rx_dma_en), .req(rx_dma_req)
  );

  always_comb begin
    flag_set              = '0;
    flag_set[FLAG_UNDER]  = tx_under;
    flag_set[FLAG_RX_OVR] = rx_drop;
    flag_set[FLAG_TX_OVR] = tx_drop;
  end

  ff_sticky #(.N(FLAG_N)) u_flags (
    .clk(clk), .rst(rst), .set(flag_set), .clr(flag_clr), .q(err_flags)
  );
endmodule

// File: rtl/ff_fifo_pair_chk.sv
module ff_fifo_pair_chk #(
  parameter int DEPTH = 8,
  parameter int DATA_W = 16,
  localparam int LW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic              tx_clr,
  input logic              rx_clr,
  input logic [2:0]        flag_clr,
  input logic              eng_tx_pop,
  input logic [DATA_W-1:0] eng_tx_data,
  input logic              eng_rx_push,
  input logic              tx_dma_en,
  input logic              rx_dma_en,
  input logic [LW-1:0]     tx_lvl_q,
  input logic [LW-1:0]     rx_lvl_q,
  input logic [CW-1:0]     tx_count,
  input logic [CW-1:0]     rx_count,
  input logic              tx_dma_req,
  input logic              rx_dma_req,
  input logic [2:0]        err_flags
);
  // R1: occupancy never exceeds the depth
  a_r1_count_bound: assert property (@(posedge clk) disable iff (rst)
    (int'(tx_count) <= DEPTH) && (int'(rx_count) <= DEPTH));

  a_r5_tx_clear_empties: assert property (@(posedge clk) disable iff (rst)
    tx_clr |=> (tx_count == '0));

  a_r5_rx_clear_empties: assert property (@(posedge clk) disable iff (rst)
    rx_clr |=> (rx_count == '0));

  a_r8_underrun_zero: assert property (@(posedge clk) disable iff (rst)
    (eng_tx_pop && tx_count == '0) |=> (eng_tx_data == '0) && err_flags[0]);

  a_r6_rx_overrun_flag: assert property (@(posedge clk) disable iff (rst)
    (eng_rx_push && !rx_clr && int'(rx_count) == DEPTH) |=> err_flags[1]);

  a_r9_flag_sticky: assert property (@(posedge clk) disable iff (rst)
    (err_flags[1] && !flag_clr[1]) |=> err_flags[1]);

  a_r3_tx_req_valid: assert property (@(posedge clk) disable iff (rst)
    tx_dma_req |-> $past(tx_dma_en) &&
      ((DEPTH - int'(tx_count)) >= (int'($past(tx_lvl_q)) + 1)));

  a_r4_rx_req_valid: assert property (@(posedge clk) disable iff (rst)
    rx_dma_req |-> $past(rx_dma_en) &&
      (int'(rx_count) >= (int'($past(rx_lvl_q)) + 1)));
endmodule

bind ff_fifo_pair ff_fifo_pair_chk #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .tx_clr(tx_clr), .rx_clr(rx_clr), .flag_clr(flag_clr),
  .eng_tx_pop(eng_tx_pop), .eng_tx_data(eng_tx_data), .eng_rx_push(eng_rx_push),
  .tx_dma_en(tx_dma_en), .rx_dma_en(rx_dma_en),
  .tx_lvl_q(tx_lvl_q), .rx_lvl_q(rx_lvl_q),
  .tx_count(tx_count), .rx_count(rx_count),
  .tx_dma_req(tx_dma_req), .rx_dma_req(rx_dma_req), .err_flags(err_flags)
);

// File: tb/tb_ff_fifo_pair.sv
`timescale 1ns/1ps
module tb_ff_fifo_pair;
  localparam int DW = 16;
  localparam int DEPTH = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_we = 0;
  logic [2:0]    cfg_tx_lvl = 0, cfg_rx_lvl = 0;
  logic          tx_dma_en = 0, rx_dma_en = 0, tx_clr = 0, rx_clr = 0;
  logic [2:0]    flag_clr = 0;
  logic          host_tx_push = 0, host_rx_pop = 0, eng_tx_pop = 0, eng_rx_push = 0;
  logic [DW-1:0] host_tx_data = 0, eng_rx_data = 0;
  logic [DW-1:0] host_rx_data, eng_tx_data;
  logic [3:0]    tx_count, rx_count;
  logic          tx_dma_req, rx_dma_req;
  logic [2:0]    err_flags;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  ff_fifo_pair #(.DATA_W(DW), .DEPTH(DEPTH)) dut (.*);

  task automatic chk(input string req, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, got, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic tx_push(input logic [DW-1:0] v);
    host_tx_push = 1; host_tx_data = v; cyc(); host_tx_push = 0;
  endtask

  task automatic rx_push(input logic [DW-1:0] v);
    eng_rx_push = 1; eng_rx_data = v; cyc(); eng_rx_push = 0;
  endtask

  task automatic tx_pop(output logic [DW-1:0] v);
    eng_tx_pop = 1; cyc(); eng_tx_pop = 0; v = eng_tx_data;
  endtask

  task automatic rx_pop(output logic [DW-1:0] v);
    host_rx_pop = 1; cyc(); host_rx_pop = 0; v = host_rx_data;
  endtask

  task automatic clear_flags();
    flag_clr = 3'b111; cyc(); flag_clr = 0;
  endtask

  task automatic t_reset_state();
    chk("R10", "tx_count", tx_count, 0);
    chk("R10", "rx_count", rx_count, 0);
    chk("R10", "err_flags", err_flags, 0);
    chk("R10", "eng_tx_data", eng_tx_data, 0);
    chk("R10", "host_rx_data", host_rx_data, 0);
    chk("R10", "rx_dma_req", rx_dma_req, 0);
    chk("R10", "tx_dma_req enabled default thr", tx_dma_req, 1);
  endtask

  task automatic t_rx_default_threshold();
    logic [DW-1:0] v;
    for (int i = 0; i < 7; i++) rx_push(DW'(100 + i));
    chk("R2", "rx req at 7 filled, default 8", rx_dma_req, 0);
    rx_push(DW'(107));
    chk("R2", "rx req at 8 filled, default 8", rx_dma_req, 1);
    chk("R1", "rx_count full", rx_count, 8);
    for (int i = 0; i < 8; i++) begin
      rx_pop(v);
      chk("R1", "rx order", v, 100 + i);
    end
    chk("R1", "rx_count drained", rx_count, 0);
  endtask

  task automatic t_tx_order();
    logic [DW-1:0] v;
    tx_push(16'hA001); tx_push(16'hB002); tx_push(16'hC003);
    chk("R1", "tx_count 3", tx_count, 3);
    tx_pop(v); chk("R1", "tx order 0", v, 16'hA001);
    tx_pop(v); chk("R1", "tx order 1", v, 16'hB002);
    tx_pop(v); chk("R1", "tx order 2", v, 16'hC003);
    chk("R1", "tx_count 0", tx_count, 0);
  endtask

  task automatic t_tx_threshold();
    logic [DW-1:0] v;
    cfg_tx_lvl = 3'd2; cfg_rx_lvl = 3'd3; cfg_we = 1; cyc(); cfg_we = 0;
    for (int i = 0; i < 5; i++) tx_push(DW'(i));
    chk("R3", "tx req 3 free thr 3", tx_dma_req, 1);
    tx_push(DW'(5));
    chk("R3", "tx req 2 free thr 3", tx_dma_req, 0);
    tx_pop(v);
    chk("R3", "tx req back at 3 free", tx_dma_req, 1);
    tx_dma_en = 0; cyc();
    chk("R3", "tx req disabled", tx_dma_req, 0);
    tx_dma_en = 1;
    tx_clr = 1; cyc(); tx_clr = 0;
    chk("R5", "tx clear empties", tx_count, 0);
  endtask

  task automatic t_rx_threshold();
    rx_dma_en = 1;
    for (int i = 0; i < 3; i++) rx_push(DW'(i));
    chk("R4", "rx req 3 filled thr 4", rx_dma_req, 0);
    rx_push(DW'(3));
    chk("R4", "rx req 4 filled thr 4", rx_dma_req, 1);
    rx_dma_en = 0; cyc();
    chk("R4", "rx req disabled", rx_dma_req, 0);
    rx_clr = 1; cyc(); rx_clr = 0;
    chk("R5", "rx clear empties", rx_count, 0);
  endtask

  task automatic t_rx_overrun();
    logic [DW-1:0] v;
    for (int i = 0; i < 8; i++) rx_push(DW'(200 + i));
    chk("R6", "no flag before overrun", err_flags[1], 0);
    rx_push(16'hDEAD);
    chk("R6", "rx overrun flag", err_flags[1], 1);
    chk("R6", "rx_count stays full", rx_count, 8);
    for (int i = 0; i < 8; i++) rx_pop(v);
    chk("R6", "last rx word is 8th, extra dropped", v, 207);
    chk("R9", "rx overrun flag sticky", err_flags[1], 1);
    flag_clr = 3'b010; cyc(); flag_clr = 0;
    chk("R9", "rx overrun flag cleared", err_flags[1], 0);
  endtask

  task automatic t_tx_overrun();
    logic [DW-1:0] v;
    for (int i = 0; i < 8; i++) tx_push(DW'(300 + i));
    tx_push(16'hBEEF);
    chk("R7", "tx overrun flag", err_flags[2], 1);
    chk("R7", "tx_count stays full", tx_count, 8);
    for (int i = 0; i < 8; i++) tx_pop(v);
    chk("R7", "last tx word is 8th, extra dropped", v, 307);
    chk("R7", "underrun not set by valid pops", err_flags[0], 0);
    clear_flags();
  endtask

  task automatic t_underrun();
    logic [DW-1:0] v;
    tx_push(16'h1234);
    tx_pop(v);
    chk("R1", "tx word before underrun", v, 16'h1234);
    tx_pop(v);
    chk("R8", "underrun data zero", v, 0);
    chk("R8", "underrun flag", err_flags[0], 1);
    clear_flags();
    chk("R9", "flags cleared", err_flags, 0);
  endtask

  task automatic t_clear_priority();
    logic [DW-1:0] v;
    tx_push(16'h5555); tx_push(16'h6666);
    tx_clr = 1; host_tx_push = 1; host_tx_data = 16'h7777; eng_tx_pop = 1;
    cyc();
    tx_clr = 0; host_tx_push = 0; eng_tx_pop = 0;
    chk("R5", "tx clear beats push", tx_count, 0);
    chk("R5", "tx clear pop returns zero", eng_tx_data, 0);
    chk("R5", "no underrun on non-empty clear", err_flags[0], 0);
    rx_push(16'h1111); rx_push(16'h2222); rx_push(16'h3333);
    rx_clr = 1; eng_rx_push = 1; eng_rx_data = 16'h4444; cyc();
    rx_clr = 0; eng_rx_push = 0;
    chk("R5", "rx clear beats push", rx_count, 0);
    tx_push(16'h0ABC);
    tx_pop(v);
    chk("R5", "tx usable after clear", v, 16'h0ABC);
  endtask

  task automatic t_flag_set_wins();
    eng_tx_pop = 1; flag_clr = 3'b001; cyc();
    eng_tx_pop = 0; flag_clr = 0;
    chk("R9", "set wins over clear", err_flags[0], 1);
    clear_flags();
    chk("R9", "cleared afterwards", err_flags[0], 0);
  endtask

  initial begin
    tx_dma_en = 1; rx_dma_en = 1;
    repeat (3) cyc();
    rst = 0;
    cyc();
    t_reset_state();
    t_rx_default_threshold();
    t_tx_order();
    t_tx_threshold();
    t_rx_threshold();
    t_rx_overrun();
    t_tx_overrun();
    t_underrun();
    t_clear_priority();
    t_flag_set_wins();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule